// File: doc/BRIEF.md
# Keyed Restart Watchdog Timer

A 32-bit down-counting watchdog that sits on a simple word-wide register bus. Software writes a reload value, sets the run bit in the control word, and must then keep feeding the timer. Feeding means writing a fixed 16-bit key into the restart port. If the count ever reaches zero while the timer runs, the block fires the actions that the control word enables. These are a system-reset request, an interrupt and an external reset strobe, each a one-cycle pulse. Firing also stops the countdown.

The countdown either steps once per bus clock or steps once per pulse of an external 1 MHz tick-enable, chosen by a control bit. A two-bit reset-mode field is passed out as a level, so that the reset logic can tell a core-only reset from a full-chip reset.

A status input reports whether the memory controller is held in reset. When that input is high at the moment of expiry, every action is vetoed, and the control word is wiped, which also disarms the timer.

Top module: `kwdt_top`

## Requirements
- R1: After reset the live counter and the reload register both hold the parameter `RESET_LOAD` (default 0x014FB180), the control word reads 0, and all pulse outputs are low.
- R2: Byte offset 0x04 is a read/write reload register. Offset 0x00 reads the live counter, and writes to 0x00 change nothing.
- R3: A write to offset 0x08 whose bits 15:0 equal 0x4755 copies the reload value into the counter, whatever bits 31:16 hold. A write with any other low half-word leaves the counter unchanged. Reads of 0x08 return 0.
- R4: The control word at offset 0x0C holds these fields: bit 0 run, bit 1 system-reset enable, bit 2 interrupt enable, bit 3 external strobe enable, bit 4 tick select, and bits 6:5 reset mode. The reset mode drives `rst_mode_o`. Bits 9:7 always read 0.
- R5: A control write that sets bit 0 while it is clear loads the counter from the reload register. A control write that keeps bit 0 set does not reload the counter.
- R6: A control write that clears bit 0 stops the countdown, and the counter then holds its value.
- R7: While the timer runs, the counter decreases by one on every clock when bit 4 is 0, and only on clocks with `tick_i` high when bit 4 is 1.
- R8: In the cycle after the counter reads zero while running, each enabled action output pulses high for exactly one cycle. The counter then stays at zero and nothing fires again until the timer is restarted.
- R9: `sys_rst_req_o`, `irq_o` and `ext_rst_o` fire only when control bits 1, 2 and 3 are set, respectively.
- R10: If `mc_rst_i` is high at expiry, no action pulses and the control word becomes 0.
- R11: Misaligned accesses and offsets 0x10 and above read 0, and writing to them changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational, 0 when not selected) |
| tick_i | input | 1 | 1 MHz tick-enable pulse |
| mc_rst_i | input | 1 | Memory controller is held in reset |
| sys_rst_req_o | output | 1 | System-reset request pulse |
| irq_o | output | 1 | Interrupt pulse |
| ext_rst_o | output | 1 | External reset strobe pulse |
| rst_mode_o | output | 2 | Reset mode: 0 for core reset, 1 for full-chip reset |

## Verification
The bench builds the block with `ADDR_W` = 6 and `RESET_LOAD` = 12. With this small reset default, expiry is reachable straight from reset, and the bench can confirm the reset value without loading a reload value first. Small reloads let the bench sweep every reload value from 0 to 5 against all eight combinations of the three action enables. For each case it predicts, cycle by cycle, the counter value and the cycle in which the pulse appears. The 64-byte window leaves unmapped and misaligned offsets to probe for R11.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

    localparam int WORD_W = 32;
    localparam logic [15:0] FEED_KEY = 16'h4755;
    localparam int N_ACT = 3;

    typedef enum logic [1:0] {
        REG_COUNT  = 2'd0,
        REG_RELOAD = 2'd1,
        REG_FEED   = 2'd2,
        REG_CTRL   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [21:0] upper;
        logic [2:0]  rsvd;
        logic [1:0]  mode;
        logic        tick_sel;
        logic        ext_en;
        logic        irq_en;
        logic        sysrst_en;
        logic        run_en;
    } ctrl_t;

    function automatic ctrl_t clean_ctrl(input logic [WORD_W-1:0] d);
        ctrl_t c;
        c = ctrl_t'(d);
        c.rsvd = '0;
        return c;
    endfunction

endpackage

// File: rtl/kwdt_regs.sv
module kwdt_regs
    import kwdt_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter logic [WORD_W-1:0] RESET_LOAD = 32'h014FB180
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic [WORD_W-1:0] cnt_i,
    input  logic              veto_clr_i,
    output ctrl_t             ctrl_o,
    output logic [WORD_W-1:0] reload_o,
    output logic              load_o
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0]  idx;
    logic              in_map;
    logic              wr_ok;
    reg_sel_e          rsel;
    ctrl_t             ctrl_q;
    logic [WORD_W-1:0] reload_q;

    assign idx    = bus_addr[ADDR_W-1:2];
    assign in_map = (bus_addr[1:0] == 2'b00) && (idx <= IDX_W'(3));
    assign rsel   = reg_sel_e'(idx[1:0]);
    assign wr_ok  = bus_sel && bus_wr && in_map;

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr && in_map) begin
            case (rsel)
                REG_COUNT:  bus_rdata = cnt_i;
                REG_RELOAD: bus_rdata = reload_q;
                REG_FEED:   bus_rdata = '0;
                REG_CTRL:   bus_rdata = ctrl_q;
                default:    bus_rdata = '0;
            endcase
        end
    end

    assign load_o = wr_ok &&
        (((rsel == REG_FEED) && (bus_wdata[15:0] == FEED_KEY)) ||
         ((rsel == REG_CTRL) && bus_wdata[0] && !ctrl_q.run_en));

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            reload_q <= RESET_LOAD;
        end else begin
            if (wr_ok && rsel == REG_RELOAD)
                reload_q <= bus_wdata;
            if (veto_clr_i)
                ctrl_q <= '0;
            else if (wr_ok && rsel == REG_CTRL)
                ctrl_q <= clean_ctrl(bus_wdata);
        end
    end

    assign ctrl_o   = ctrl_q;
    assign reload_o = reload_q;

    AST_RELOAD_GUARD: assert property (@(posedge clk) disable iff (rst)
        !(wr_ok && rsel == REG_RELOAD) |=> $stable(reload_q)); // R11

    AST_VETO_WIPE: assert property (@(posedge clk) disable iff (rst)
        veto_clr_i |=> (ctrl_q == '0)); // R10

endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter
    import kwdt_pkg::*;
#(
    parameter logic [WORD_W-1:0] RESET_LOAD = 32'h014FB180
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [WORD_W-1:0] reload_i,
    input  ctrl_t             ctrl_i,
    input  logic              tick_i,
    input  logic              mc_rst_i,
    output logic [WORD_W-1:0] cnt_o,
    output logic              veto_clr_o,
    output logic [N_ACT-1:0]  act_o
);
    logic [WORD_W-1:0] cnt_q;
    logic              done_q;
    logic              running;
    logic              step;
    logic              expire;
    logic [N_ACT-1:0]  gate_en;
    logic [N_ACT-1:0]  act_q;

    assign running = ctrl_i.run_en && !done_q;
    assign step    = ctrl_i.tick_sel ? tick_i : 1'b1;
    assign expire  = running && (cnt_q == '0) && !load_i;
    assign veto_clr_o = expire && mc_rst_i;
    assign gate_en = {ctrl_i.ext_en, ctrl_i.irq_en, ctrl_i.sysrst_en};

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= RESET_LOAD;
            done_q <= 1'b0;
        end else if (load_i) begin
            cnt_q  <= reload_i;
            done_q <= 1'b0;
        end else if (expire) begin
            done_q <= 1'b1;
        end else if (running && step) begin
            cnt_q <= cnt_q - WORD_W'(1);
        end
    end

    for (genvar g = 0; g < N_ACT; g++) begin : g_act
        always_ff @(posedge clk) begin
            if (rst)
                act_q[g] <= 1'b0;
            else
                act_q[g] <= expire && !mc_rst_i && gate_en[g];
        end
    end

    assign cnt_o = cnt_q;
    assign act_o = act_q;

    AST_DEC_ONE: assert property (@(posedge clk) disable iff (rst)
        (running && step && cnt_q != '0 && !load_i) |=> (cnt_q == $past(cnt_q) - WORD_W'(1))); // R7

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_i.run_en && !load_i) |=> $stable(cnt_q)); // R6

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        act_q[0] |=> !act_q[0]); // R8

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        act_q[1] |-> ($past(ctrl_i.irq_en) && !$past(mc_rst_i))); // R9

    AST_VETO_SILENT: assert property (@(posedge clk) disable iff (rst)
        (act_q != '0) |-> !$past(mc_rst_i)); // R10

endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
    import kwdt_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter logic [31:0] RESET_LOAD = 32'h014FB180
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              tick_i,
    input  logic              mc_rst_i,
    output logic              sys_rst_req_o,
    output logic              irq_o,
    output logic              ext_rst_o,
    output logic [1:0]        rst_mode_o
);
    ctrl_t             ctrl;
    logic [WORD_W-1:0] reload;
    logic [WORD_W-1:0] cnt;
    logic              load;
    logic              veto_clr;
    logic [N_ACT-1:0]  act;

    kwdt_regs #(.ADDR_W(ADDR_W), .RESET_LOAD(RESET_LOAD)) u_regs (
        .clk(clk), .rst(rst),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cnt_i(cnt), .veto_clr_i(veto_clr),
        .ctrl_o(ctrl), .reload_o(reload), .load_o(load)
    );

    kwdt_counter #(.RESET_LOAD(RESET_LOAD)) u_counter (
        .clk(clk), .rst(rst),
        .load_i(load), .reload_i(reload), .ctrl_i(ctrl),
        .tick_i(tick_i), .mc_rst_i(mc_rst_i),
        .cnt_o(cnt), .veto_clr_o(veto_clr), .act_o(act)
    );

    assign sys_rst_req_o = act[0];
    assign irq_o         = act[1];
    assign ext_rst_o     = act[2];
    assign rst_mode_o    = ctrl.mode;

endmodule

// File: tb/kwdt_top_bench.sv
`timescale 1ns/1ps
module kwdt_top_bench;
    localparam int AW = 6;
    localparam logic [31:0] RLOAD = 32'd12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_sel = 1'b0, bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic tick_i = 1'b0, mc_rst_i = 1'b0;
    logic sys_rst_req_o, irq_o, ext_rst_o;
    logic [1:0] rst_mode_o;

    int n_chk = 0;
    int n_bad = 0;
    bit ended = 0;

    always #2.5 clk = ~clk;

    kwdt_top #(.ADDR_W(AW), .RESET_LOAD(RLOAD)) u_kwdt_top (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick_i(tick_i), .mc_rst_i(mc_rst_i),
        .sys_rst_req_o(sys_rst_req_o), .irq_o(irq_o), .ext_rst_o(ext_rst_o),
        .rst_mode_o(rst_mode_o)
    );

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // called at a falling edge; the write lands on the next rising edge
    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #0.5;
        d = bus_rdata;
        bus_sel = 1'b0;
        #0.5;
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic logic [31:0] outs();
        return {29'd0, ext_rst_o, irq_o, sys_rst_req_o};
    endfunction

    initial begin
        #200000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        cyc(3);
        rst = 1'b0;
        cyc(1);

        // R1 reset state
        rd(6'h00, d); chk("R1 counter", d, RLOAD);
        rd(6'h04, d); chk("R1 reload", d, RLOAD);
        rd(6'h0C, d); chk("R1 ctrl", d, 32'd0);
        chk("R1 outputs", outs(), 32'd0);

        // R2 reload RW, counter read-only
        wr(6'h00, 32'd5); rd(6'h00, d); chk("R2 status write ignored", d, RLOAD);
        wr(6'h04, 32'd7); rd(6'h04, d); chk("R2 reload rw", d, 32'd7);

        // R3 feed port reads zero
        rd(6'h08, d); chk("R3 feed read", d, 32'd0);

        // R11 unmapped and misaligned
        rd(6'h10, d); chk("R11 unmapped 0x10", d, 32'd0);
        rd(6'h3C, d); chk("R11 unmapped 0x3C", d, 32'd0);
        rd(6'h05, d); chk("R11 misaligned read", d, 32'd0);
        wr(6'h06, 32'd99); rd(6'h04, d); chk("R11 misaligned write", d, 32'd7);
        wr(6'h24, 32'hFFFF_FFFF); rd(6'h0C, d); chk("R11 unmapped write ctrl", d, 32'd0);
        rd(6'h04, d); chk("R11 unmapped write reload", d, 32'd7);

        // R4 field layout, reserved bits
        wr(6'h0C, 32'h0000_03FE); rd(6'h0C, d); chk("R4 rsvd zero", d, 32'h0000_007E);
        chk("R4 mode out", {30'd0, rst_mode_o}, 32'd3);
        wr(6'h0C, 32'h0000_0020); chk("R4 mode full chip", {30'd0, rst_mode_o}, 32'd1);
        wr(6'h0C, 32'h0);

        // R3 key matching
        wr(6'h08, 32'h0000_4756); rd(6'h00, d); chk("R3 bad key", d, RLOAD);
        wr(6'h08, 32'hABCD_4755); rd(6'h00, d); chk("R3 good key", d, 32'd7);
        cyc(3); rd(6'h00, d); chk("R6 idle hold", d, 32'd7);

        // R7/R8/R9 sweep over reload values and action enables
        for (int r = 0; r <= 5; r++) begin
            for (int g = 0; g < 8; g++) begin
                wr(6'h04, r);
                wr(6'h0C, (g << 1) | 1);
                rd(6'h00, d); chk("R5 load on enable", d, r);
                for (int k = 1; k <= r; k++) begin
                    @(negedge clk);
                    rd(6'h00, d); chk("R7 per-clock decrement", d, r - k);
                    chk("R8 no early pulse", outs(), 32'd0);
                end
                @(negedge clk);
                chk("R9 action gating", outs(), g);
                @(negedge clk);
                chk("R8 single pulse", outs(), 32'd0);
                cyc(3);
                chk("R8 no repeat", outs(), 32'd0);
                rd(6'h00, d); chk("R8 stays zero", d, 32'd0);
                wr(6'h0C, 32'h0);
            end
        end

        // R5 enable kept set does not reload
        wr(6'h04, 32'd10);
        wr(6'h0C, 32'h1);
        cyc(3); rd(6'h00, d); chk("R7 running", d, 32'd7);
        wr(6'h0C, 32'h3); rd(6'h00, d); chk("R5 no reload", d, 32'd6);
        wr(6'h08, 32'h0000_4755); rd(6'h00, d); chk("R3 feed while running", d, 32'd10);

        // R6 disable stops countdown
        wr(6'h0C, 32'h0); rd(6'h00, d); chk("R6 stop", d, 32'd9);
        cyc(5); rd(6'h00, d); chk("R6 hold", d, 32'd9);

        // R7 tick mode
        wr(6'h04, 32'd4);
        wr(6'h0C, 32'h11);
        cyc(3); rd(6'h00, d); chk("R7 no tick no step", d, 32'd4);
        tick_i = 1'b1;
        @(negedge clk); rd(6'h00, d); chk("R7 tick step", d, 32'd3);
        @(negedge clk); tick_i = 1'b0;
        rd(6'h00, d); chk("R7 tick step 2", d, 32'd2);
        cyc(2); rd(6'h00, d); chk("R7 tick hold", d, 32'd2);
        wr(6'h0C, 32'h0);

        // R10 veto
        wr(6'h04, 32'd2);
        mc_rst_i = 1'b1;
        wr(6'h0C, 32'h0F);
        cyc(2); rd(6'h00, d); chk("R10 reached zero", d, 32'd0);
        @(negedge clk);
        chk("R10 no action", outs(), 32'd0);
        rd(6'h0C, d); chk("R10 ctrl wiped", d, 32'd0);
        cyc(3); chk("R10 quiet", outs(), 32'd0);
        mc_rst_i = 1'b0;
        wr(6'h0C, 32'h03);
        cyc(2);
        @(negedge clk);
        chk("R10 rearm fires", outs(), 32'd1);

        finish_run();
    end
endmodule